// File: doc/BRIEF.md
# Four-Phase Interleaved Boost PWM Sequencer

This block drives the gates of a four-phase interleaved boost stage from one shared duty word. A single period counter spaces the four phases a quarter period apart. Each phase gets a low-side enable and a synchronous-rectifier enable. For an active phase the two enables are always opposite; for an inactive phase both are off.

After enable, a soft-start sequence runs. It starts with only the first phase active, in burst mode, where that phase fires on only a fraction of switching periods. The firing fraction rises step by step until the first phase fires every period. The other phases are then added one at a time, in an order chosen so that two active phases sit half a period apart. At every step boundary, a "power increasing" input decides whether the sequence moves forward one step or back one step.

Each phase has cycle-by-cycle overcurrent protection. An overtemperature flag blocks every low-side switch while it is raised.

Top module: `ilv_pwm_sequencer`

## Requirements
- R1: While `en_i` is low, every low-side and rectifier enable is 0 and `n_active_o` is 0. The period counter and the soft-start state return to their start values, so the next enable begins again at level 1.
- R2: The switching period is PERIOD clock cycles. Phase index k (0..3) starts its pulse at count k*PERIOD/4 of the period. In a firing period its low-side enable stays high for `duty_i` consecutive cycles.
- R3: At level 1, only phase index 0 is active. It fires on one switching period out of 15: counting from the enable, it fires in periods 15, 30, and so on.
- R4: At each step boundary (every STEP_PERIODS periods) with `pwr_up_i` high, the level rises by one. Levels 1 to 15 give phase 0 a density of level/15; at level 15 it fires every period.
- R5: Above full density, phases are added in the order index 2, then index 1, then index 3. The active sets are 0001, 0101, 0111 and 1111 (bit k = phase index k) at levels 15 or below, 16, 17 and 18.
- R6: At a step boundary with `pwr_up_i` low, the level falls by one, stopping at 1. This removes phases in the reverse of the R5 order.
- R7: For an active phase, `sr_o[k]` is the complement of `ls_o[k]` in every cycle. For an inactive phase, both are 0.
- R8: When `oc_i[k]` is high, `ls_o[k]` drops in the same cycle. It stays low, with `sr_o[k]` high, for the rest of that phase's period.
- R9: A phase cut off by overcurrent turns its low-side enable on again at the start of its next period.
- R10: While `ot_i` is high, all four low-side enables are 0. Normal pulses resume once it clears.
- R11: `n_active_o` equals the number of active phases: 1, 2, 3 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| en_i | input | 1 | Run enable; low clears the sequencer |
| duty_i | input | DUTY_W | On-time in clock cycles per period |
| oc_i | input | 4 | Overcurrent flag for each phase |
| ot_i | input | 1 | Overtemperature flag |
| pwr_up_i | input | 1 | High when generated power is rising |
| ls_o | output | 4 | Low-side switch enable for each phase |
| sr_o | output | 4 | Synchronous-rectifier enable for each phase |
| n_active_o | output | 3 | Number of active phases |

## Verification
The assertions check every cycle that:
- the period counter advances by one;
- the level changes only at step boundaries, and by exactly one step in the direction `pwr_up_i` selects;
- an overcurrent cuts the low-side enable into the next cycle;
- overtemperature clears all low-side enables;
- the count of driven enables matches `n_active_o`.

The 1-in-15 burst pattern, the activation order, the quarter-period offsets, the pulse width and the re-arm at the next period can only be shown by the bench's scenarios. These scenarios count pulses across whole windows of periods aligned to the enable.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  localparam int ACC_W = 8;

  typedef struct packed {
    logic             fire;
    logic [ACC_W-1:0] acc;
  } burst_t;

  // Density accumulator: fire when the running sum crosses the denominator.
  function automatic burst_t burst_next(logic [ACC_W-1:0] acc, int dens, int den);
    burst_t r;
    int     sum;
    sum    = int'(acc) + dens;
    r.fire = (sum >= den);
    r.acc  = r.fire ? ACC_W'(sum - den) : ACC_W'(sum);
    return r;
  endfunction

  // Active set per level: index 0, then 2, then 1, then 3.
  function automatic logic [3:0] active_mask(int lvl, int den);
    if (lvl <= den)          return 4'b0001;
    else if (lvl == den + 1) return 4'b0101;
    else if (lvl == den + 2) return 4'b0111;
    return 4'b1111;
  endfunction

  function automatic logic [2:0] phase_count(int lvl, int den);
    if (lvl <= den) return 3'd1;
    return 3'(lvl - den + 1);
  endfunction

  // Position inside a phase's own period, shifted by its offset.
  function automatic int phase_local(int cnt, int off, int period);
    return (cnt >= off) ? (cnt - off) : (cnt + period - off);
  endfunction

endpackage

// File: rtl/ilv_period_timer.sv
module ilv_period_timer #(
  parameter int PERIOD       = 500,
  parameter int STEP_PERIODS = 16,
  parameter int CNT_W        = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             step_o
);
  localparam int STP_W = $clog2(STEP_PERIODS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [STP_W-1:0] stp_q;

  assign wrap_o = en_i && (cnt_q == CNT_W'(PERIOD - 1));
  assign step_o = wrap_o && (stp_q == STP_W'(STEP_PERIODS - 1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      cnt_q <= '0;
      stp_q <= '0;
    end else if (wrap_o) begin
      cnt_q <= '0;
      stp_q <= step_o ? '0 : stp_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_cnt_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !wrap_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < PERIOD);

endmodule

// File: rtl/ilv_softstart.sv
module ilv_softstart
  import ilv_pkg::*;
#(
  parameter int BURST_DEN = 15,
  parameter int LVL_W     = $clog2(BURST_DEN + 4)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       wrap_i,
  input  logic       step_i,
  input  logic       pwr_up_i,
  output logic [3:0] active_o,
  output logic       fire0_o,
  output logic [2:0] n_active_o
);
  localparam int LVL_MAX = BURST_DEN + 3;

  logic [LVL_W-1:0] level_q;
  logic [ACC_W-1:0] acc_q;
  logic             fire_q;
  burst_t           nxt;

  always_comb nxt = burst_next(acc_q, int'(level_q), BURST_DEN);

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      level_q <= LVL_W'(1);
      acc_q   <= '0;
      fire_q  <= 1'b0;
    end else begin
      if (wrap_i) begin
        if (int'(level_q) >= BURST_DEN) begin
          fire_q <= 1'b1;
          acc_q  <= '0;
        end else begin
          fire_q <= nxt.fire;
          acc_q  <= nxt.acc;
        end
      end
      if (step_i) begin
        if (pwr_up_i) begin
          if (int'(level_q) < LVL_MAX) level_q <= level_q + 1'b1;
        end else if (level_q > LVL_W'(1)) begin
          level_q <= level_q - 1'b1;
        end
      end
    end
  end

  assign active_o   = en_i ? active_mask(int'(level_q), BURST_DEN) : 4'b0000;
  assign n_active_o = en_i ? phase_count(int'(level_q), BURST_DEN) : 3'd0;
  assign fire0_o    = fire_q;

  assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !step_i) |=> $stable(level_q));

  assert_level_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && step_i && pwr_up_i && int'(level_q) < LVL_MAX)
      |=> (level_q == $past(level_q) + 1'b1));

  assert_level_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && step_i && !pwr_up_i && level_q > LVL_W'(1))
      |=> (level_q == $past(level_q) - 1'b1));

endmodule

// File: rtl/ilv_phase_gate.sv
module ilv_phase_gate
  import ilv_pkg::*;
#(
  parameter int PERIOD = 500,
  parameter int OFFSET = 0,
  parameter int CNT_W  = $clog2(PERIOD),
  parameter int DUTY_W = $clog2(PERIOD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              active_i,
  input  logic              fire_i,
  input  logic              oc_i,
  input  logic              ot_i,
  output logic              ls_o,
  output logic              sr_o
);
  int   loc;
  logic base;
  logic last;
  logic trip_q;

  always_comb loc = phase_local(int'(cnt_i), OFFSET, PERIOD);

  assign base = en_i && active_i && fire_i && (loc < int'(duty_i));
  assign last = (loc == PERIOD - 1);

  // Overcurrent latch; re-armed at the end of this phase's own period.
  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) trip_q <= 1'b0;
    else if (last)       trip_q <= 1'b0;
    else if (oc_i)       trip_q <= 1'b1;
  end

  assign ls_o = base && !oc_i && !trip_q && !ot_i;
  assign sr_o = en_i && active_i && !ls_o;

  assert_oc_holds_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && oc_i && !last) |=> !ls_o);

endmodule

// File: rtl/ilv_pwm_sequencer.sv
module ilv_pwm_sequencer #(
  parameter int PERIOD       = 500,
  parameter int DUTY_W       = $clog2(PERIOD + 1),
  parameter int BURST_DEN    = 15,
  parameter int STEP_PERIODS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [3:0]        oc_i,
  input  logic              ot_i,
  input  logic              pwr_up_i,
  output logic [3:0]        ls_o,
  output logic [3:0]        sr_o,
  output logic [2:0]        n_active_o
);
  localparam int NPH   = 4;
  localparam int CNT_W = $clog2(PERIOD);
  localparam int QTR   = PERIOD / NPH;
  localparam int LVL_W = $clog2(BURST_DEN + 4);

  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             step;
  logic [3:0]       active;
  logic             fire0;
  logic [NPH-1:0]   phase_fire;

  ilv_period_timer #(
    .PERIOD(PERIOD), .STEP_PERIODS(STEP_PERIODS), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .en_i(en_i),
    .cnt_o(cnt), .wrap_o(wrap), .step_o(step)
  );

  ilv_softstart #(
    .BURST_DEN(BURST_DEN), .LVL_W(LVL_W)
  ) u_soft (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .wrap_i(wrap), .step_i(step),
    .pwr_up_i(pwr_up_i), .active_o(active), .fire0_o(fire0),
    .n_active_o(n_active_o)
  );

  generate
    for (genvar k = 0; k < NPH; k++) begin : g_ph
      if (k == 0) begin : g_burst
        assign phase_fire[k] = fire0;
      end else begin : g_full
        assign phase_fire[k] = 1'b1;
      end
      ilv_phase_gate #(
        .PERIOD(PERIOD), .OFFSET(k * QTR), .CNT_W(CNT_W), .DUTY_W(DUTY_W)
      ) u_gate (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .cnt_i(cnt), .duty_i(duty_i),
        .active_i(active[k]), .fire_i(phase_fire[k]), .oc_i(oc_i[k]),
        .ot_i(ot_i), .ls_o(ls_o[k]), .sr_o(sr_o[k])
      );
    end
  endgenerate

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (ls_o == 4'b0000 && sr_o == 4'b0000 && n_active_o == 3'd0));

  assert_ot_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ot_i |-> (ls_o == 4'b0000));

  assert_count_matches_R11: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> ($countones(ls_o | sr_o) == int'(n_active_o)));

endmodule

// File: tb/tb_ilv_pwm_sequencer.sv
module tb_ilv_pwm_sequencer;
  localparam int P  = 40;
  localparam int DW = $clog2(P + 1);
  localparam int Q  = P / 4;
  localparam int D  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [DW-1:0] duty = DW'(D);
  logic [3:0]    oc = 4'b0000;
  logic          ot = 1'b0;
  logic          pwr_up = 1'b0;
  logic [3:0]    ls, sr;
  logic [2:0]    nact;

  int checks = 0, errors = 0, cyc = 0, win = 0, mask_err = 0;
  int rises[4], highs[4], first[4];
  logic [3:0] prev, exp_mask;
  bit obs = 0;

  ilv_pwm_sequencer #(.PERIOD(P), .BURST_DEN(15), .STEP_PERIODS(16)) dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .duty_i(duty), .oc_i(oc), .ot_i(ot),
    .pwr_up_i(pwr_up), .ls_o(ls), .sr_o(sr), .n_active_o(nact)
  );

  always #4 clk = ~clk;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step_cycle();
    @(negedge clk);
    if (obs) begin
      for (int k = 0; k < 4; k++) begin
        if (ls[k] && !prev[k]) begin
          rises[k]++;
          if (first[k] < 0) first[k] = win;
        end
        if (ls[k]) highs[k]++;
      end
      if (((ls & sr) != 4'b0000) || ((ls | sr) != exp_mask)) mask_err++;
      prev = ls;
      win++;
    end
    @(posedge clk); #1;
    cyc++;
  endtask

  task automatic skip_to(input int per);
    while (cyc < per * P) step_cycle();
  endtask

  task automatic observe(input int nper, input logic [3:0] m, input int oc_at, input logic [3:0] ocm);
    for (int k = 0; k < 4; k++) begin rises[k] = 0; highs[k] = 0; first[k] = -1; end
    prev = 4'b0000; win = 0; mask_err = 0; exp_mask = m; obs = 1;
    repeat (nper * P) begin
      oc = (win == oc_at) ? ocm : 4'b0000;
      step_cycle();
    end
    oc = 4'b0000; obs = 0;
    chk(mask_err, 0, "R7 rectifier complement / inactive off");
  endtask

  task automatic t_reset();
    repeat (4) @(posedge clk);
    #1;
    chk(int'(ls), 0, "R1 reset low-side");
    chk(int'(sr), 0, "R1 reset rectifier");
    chk(int'(nact), 0, "R1 reset count");
    rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic t_burst();
    pwr_up = 1'b0; en = 1'b1; cyc = 0;
    observe(45, 4'b0001, -1, 4'b0000);
    chk(rises[0], 2, "R3 level-1 burst fires 2 of 45 periods");
    chk(int'(nact), 1, "R11 one phase in burst");
  endtask

  task automatic t_disable();
    en = 1'b0;
    repeat (3) step_cycle();
    @(negedge clk);
    chk(int'(ls), 0, "R1 disabled low-side");
    chk(int'(sr), 0, "R1 disabled rectifier");
    chk(int'(nact), 0, "R1 disabled count");
    @(posedge clk); #1;
  endtask

  task automatic t_ramp();
    pwr_up = 1'b1; en = 1'b1; cyc = 0;
    skip_to(226);
    observe(12, 4'b0001, -1, 4'b0000);
    chk(rises[0], 12, "R4 full density fires every period");
    chk(int'(nact), 1, "R11 one phase at level 15");
    skip_to(242);
    observe(2, 4'b0101, -1, 4'b0000);
    chk(rises[0] + 10 * rises[2] + 100 * rises[1] + 1000 * rises[3], 22, "R5 second phase is index 2");
    chk(int'(nact), 2, "R11 two phases");
    skip_to(258);
    observe(2, 4'b0111, -1, 4'b0000);
    chk(rises[0] + 10 * rises[2] + 100 * rises[1] + 1000 * rises[3], 222, "R5 third phase is index 1");
    chk(int'(nact), 3, "R11 three phases");
    skip_to(274);
    observe(1, 4'b1111, -1, 4'b0000);
    chk(int'(nact), 4, "R11 four phases");
    for (int k = 0; k < 4; k++) begin
      chk(first[k], k * Q, "R2 quarter-period offset");
      chk(highs[k], D, "R2 pulse width equals duty");
    end
  endtask

  task automatic t_overcurrent();
    observe(1, 4'b1111, Q + 2, 4'b0010);
    chk(highs[1], 2, "R8 overcurrent cuts rest of pulse");
    chk(highs[0], D, "R8 other phases untouched");
    observe(1, 4'b1111, -1, 4'b0000);
    chk(highs[1], D, "R9 re-armed next period");
  endtask

  task automatic t_overtemp();
    ot = 1'b1;
    observe(1, 4'b1111, -1, 4'b0000);
    chk(highs[0] + highs[1] + highs[2] + highs[3], 0, "R10 overtemperature blocks all");
    ot = 1'b0;
    observe(1, 4'b1111, -1, 4'b0000);
    chk(highs[0] + highs[1] + highs[2] + highs[3], 4 * D, "R10 resumes after clear");
  endtask

  task automatic t_stepback();
    pwr_up = 1'b0;
    skip_to(290);
    @(negedge clk);
    chk(int'(nact), 3, "R6 first step back");
    @(posedge clk); #1; cyc++;
    skip_to(306);
    observe(1, 4'b0101, -1, 4'b0000);
    chk(int'(nact), 2, "R6 second step back removes index 1");
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_burst();
    t_disable();
    t_ramp();
    t_overcurrent();
    t_overtemp();
    t_stepback();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule